// File: doc/BRIEF.md
# Low-Frequency Watchdog with Power-of-Two Postscaler

This block is a watchdog timer that runs on a slow, free-running internal oscillator clock. A fixed base divider splits that clock into base ticks, by default one every 128 cycles. A postscaler then counts the base ticks. A 4-bit select value stretches the timeout by a factor of 2^N, from 1:1 up to 1:32,768.

Software keeps the watchdog quiet with a clear strobe. Entry into sleep and a clock-failure indication also restart the count. When the count runs out, the block sends a one-cycle request. This is a reset request while the device runs, or a wake-up request while it sleeps.

The watchdog runs when the static configuration enable is set. When that enable is clear, a software enable bit decides alone whether it runs. While it runs, the block also drives an enable output to the oscillator.

A small state machine turns the counter's expiry into the request pulses. Its states are:
- `WD_IDLE`: disabled.
- `WD_ARMED`: counting.
- `WD_BITE_RST`: one cycle of reset request.
- `WD_BITE_WAKE`: one cycle of wake-up request.

Its transitions are:
- IDLE→ARMED when the watchdog becomes enabled.
- ARMED→IDLE when it becomes disabled.
- ARMED (or IDLE)→BITE_RST on expiry while awake.
- ARMED (or IDLE)→BITE_WAKE on expiry while asleep.
- BITE_*→ARMED when still enabled.
- BITE_*→IDLE when disabled.

Top module: `lfo_watchdog`

## Requirements
- R1: The watchdog runs exactly when `cfg_en` or `sw_en` is 1. `osc_en` is 1 exactly when it runs.
- R2: From a zero count, the first request is high in the cycle after the (128·2^`ps_sel`)-th rising edge that counts. A counting edge is one where the watchdog runs and no clear source is active.
- R3: Each request is high for exactly one cycle. The counters restart from zero at the expiry edge, so the next request follows 128·2^`ps_sel` counting edges later.
- R4: A cycle with `clr_stb`=1 returns both counters to zero. The full period is then counted again from the next edge.
- R5: A cycle with `sleep_stb`=1 returns both counters to zero, in the same way as R4.
- R6: While `clk_fail`=1, both counters are held at zero. Counting resumes from zero after it drops.
- R7: On expiry with `in_sleep`=1, `wake_req` pulses and `rst_req` stays 0. On expiry with `in_sleep`=0, `rst_req` pulses and `wake_req` stays 0. The two requests are never high together.
- R8: While disabled, the counters are held at zero and no request is raised. After re-enable, the full period is counted from zero.
- R9: `rst_n`=0 clears the counters and the requests asynchronously. After release, the full period is counted from zero.
- R10: While `cfg_en`=1, the value of `sw_en` has no effect on counting or on the request timing.
- R11: A clear source active on the edge that would expire wins. No request is raised, and the counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| cfg_en | input | 1 | Static configuration enable |
| sw_en | input | 1 | Software enable, used only when `cfg_en`=0 |
| clr_stb | input | 1 | Clear-watchdog strobe |
| sleep_stb | input | 1 | Sleep-entry strobe |
| clk_fail | input | 1 | Clock-failure indication |
| in_sleep | input | 1 | 1 while the device is in sleep or a power-managed mode |
| ps_sel | input | 4 | Postscale select N, ratio 2^N |
| osc_en | output | 1 | Enable to the watchdog oscillator |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The timeout period is measured at select values 0, 1, 3 and 8, with the request sampled one cycle before, at and after the expected edge. Two successive expiries are checked at each select value. This separates an off-by-one in the base divider from a wrong postscaler tap, and separates a missing restart from a missing pulse end.

The clear strobe, the sleep strobe and a held clock-failure flag are each applied shortly before expiry. The request must then move a full period later, which shows that each source resets both stages.

Runs with `in_sleep` high, with only the software enable, with the software enable toggled under the configuration enable, with the watchdog disabled mid-count, and with a device reset mid-count show apart the wake and reset paths, the enable priority, and the restart-from-zero rules.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // default base divider and select width
    localparam int WD_BASE_DIV_DEF = 128;
    localparam int WD_SEL_W_DEF    = 4;

    // request state machine
    typedef enum logic [1:0] {
        WD_IDLE      = 2'd0,
        WD_ARMED     = 2'd1,
        WD_BITE_RST  = 2'd2,
        WD_BITE_WAKE = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdog_gate.sv
module wdog_gate (
    input  logic cfg_en,
    input  logic sw_en,
    input  logic clr_stb,
    input  logic sleep_stb,
    input  logic clk_fail,
    output logic run,
    output logic flush
);

    // configuration enable overrides; software enable matters only when it is off
    always_comb begin
        if (cfg_en) begin
            run = 1'b1;
        end else begin
            run = sw_en;
        end
    end

    // any clear source, or a stopped watchdog, forces both counters to zero
    always_comb begin
        flush = clr_stb | sleep_stb | clk_fail | ~run;
    end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    output logic tick
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        tick    = at_last & ~flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (flush) begin
            cnt_q <= '0;
        end else if (at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PRE_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0)); // R4
    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    localparam int NTAP = 1 << SEL_W;
    localparam int PS_W = NTAP - 1;

    logic [PS_W-1:0] cnt_q;
    logic [NTAP-1:0] term;

    // term[i]: the low i bits of the count are all ones, i.e. 2^i ticks seen
    generate
        for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
            if (gi == 0) begin : g_first
                assign term[gi] = 1'b1;
            end else begin : g_rest
                assign term[gi] = &cnt_q[gi-1:0];
            end
        end
    endgenerate

    always_comb begin
        expire = tick & term[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (flush) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_POST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0)); // R3
    AST_POST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0)); // R8
    AST_POST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flush) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic expire,
    input  logic in_sleep,
    output logic rst_req,
    output logic wake_req
);

    wd_state_e state_q;
    wd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (expire) begin
                    state_d = in_sleep ? WD_BITE_WAKE : WD_BITE_RST;
                end else if (run) begin
                    state_d = WD_ARMED;
                end
            end
            WD_ARMED: begin
                if (expire) begin
                    state_d = in_sleep ? WD_BITE_WAKE : WD_BITE_RST;
                end else if (!run) begin
                    state_d = WD_IDLE;
                end
            end
            WD_BITE_RST, WD_BITE_WAKE: begin
                if (expire) begin
                    state_d = in_sleep ? WD_BITE_WAKE : WD_BITE_RST;
                end else if (run) begin
                    state_d = WD_ARMED;
                end else begin
                    state_d = WD_IDLE;
                end
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        rst_req  = 1'b0;
        wake_req = 1'b0;
        unique case (state_q)
            WD_BITE_RST:  rst_req  = 1'b1;
            WD_BITE_WAKE: wake_req = 1'b1;
            default: ;
        endcase
    end

    AST_BITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (rst_req || wake_req)); // R2
    AST_WAKE_WHEN_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && in_sleep) |=> (wake_req && !rst_req)); // R7
    AST_RST_WHEN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !in_sleep) |=> (rst_req && !wake_req)); // R7
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R3
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req); // R3
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_req)); // R7

endmodule

// File: rtl/lfo_watchdog.sv
module lfo_watchdog
    import wdog_pkg::*;
#(
    parameter int BASE_DIV = WD_BASE_DIV_DEF,
    parameter int SEL_W    = WD_SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             sw_en,
    input  logic             clr_stb,
    input  logic             sleep_stb,
    input  logic             clk_fail,
    input  logic             in_sleep,
    input  logic [SEL_W-1:0] ps_sel,
    output logic             osc_en,
    output logic             rst_req,
    output logic             wake_req
);

    logic run;
    logic flush;
    logic tick;
    logic expire;

    wdog_gate u_gate (
        .cfg_en    (cfg_en),
        .sw_en     (sw_en),
        .clr_stb   (clr_stb),
        .sleep_stb (sleep_stb),
        .clk_fail  (clk_fail),
        .run       (run),
        .flush     (flush)
    );

    assign osc_en = run;

    wdog_prescale #(.DIV(BASE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .tick  (tick)
    );

    wdog_postscale #(.SEL_W(SEL_W)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .tick   (tick),
        .sel    (ps_sel),
        .expire (expire)
    );

    wdog_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .expire   (expire),
        .in_sleep (in_sleep),
        .rst_req  (rst_req),
        .wake_req (wake_req)
    );

    AST_REQ_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> $past(osc_en)); // R1
    AST_CLEAR_BLOCKS_BITE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb || sleep_stb || clk_fail) |=> !(rst_req || wake_req)); // R11

endmodule

// File: tb/test_lfo_watchdog.sv
`timescale 1ns/1ps
module test_lfo_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, sw_en = 1'b0, clr_stb = 1'b0, sleep_stb = 1'b0;
    logic       clk_fail = 1'b0, in_sleep = 1'b0;
    logic [3:0] ps_sel = 4'd0;
    logic       osc_en, rst_req, wake_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lfo_watchdog i_lfo_watchdog (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .sw_en(sw_en),
        .clr_stb(clr_stb), .sleep_stb(sleep_stb), .clk_fail(clk_fail),
        .in_sleep(in_sleep), .ps_sel(ps_sel), .osc_en(osc_en),
        .rst_req(rst_req), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // n rising edges, ending on a falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic idle();
        cfg_en = 0; sw_en = 0; clr_stb = 0; sleep_stb = 0; clk_fail = 0; in_sleep = 0;
        step(2);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 rst_req in reset", rst_req, 1'b0);
        chk("R9 wake_req in reset", wake_req, 1'b0);
        chk("R1 osc_en off", osc_en, 1'b0);
        rst_n = 1;
        step(1);
    endtask

    // period and restart at a given select, awake or asleep, via cfg or sw enable
    task automatic t_period(input int sel, input bit asleep, input bit use_sw);
        int k = 128 << sel;
        idle();
        ps_sel = 4'(sel); in_sleep = asleep;
        if (use_sw) sw_en = 1; else cfg_en = 1;
        #1 chk(use_sw ? "R1 osc_en by sw" : "R1 osc_en by cfg", osc_en, 1'b1);
        step(k - 1);
        chk("R2 no request before period", rst_req | wake_req, 1'b0);
        step(1);
        if (asleep) begin
            chk("R7 wake_req on expiry asleep", wake_req, 1'b1);
            chk("R7 no rst_req asleep", rst_req, 1'b0);
        end else begin
            chk(use_sw ? "R1 rst_req with sw only" : "R2 rst_req at period", rst_req, 1'b1);
            chk("R7 no wake_req awake", wake_req, 1'b0);
        end
        step(1);
        chk("R3 single-cycle pulse", rst_req | wake_req, 1'b0);
        step(k - 2);
        chk("R3 quiet before second expiry", rst_req | wake_req, 1'b0);
        step(1);
        chk("R3 second expiry after full period", asleep ? wake_req : rst_req, 1'b1);
    endtask

    // kind: 0 clear strobe, 1 sleep strobe, 2 clock failure held 3 cycles
    task automatic t_clear(input int kind);
        int k = 512;
        int hold = (kind == 2) ? 3 : 1;
        string tag = (kind == 0) ? "R4 clr_stb" : (kind == 1) ? "R5 sleep_stb" : "R6 clk_fail";
        idle();
        ps_sel = 4'd2; cfg_en = 1;
        step(k - 10);
        if (kind == 0) clr_stb = 1; else if (kind == 1) sleep_stb = 1; else clk_fail = 1;
        step(hold);
        clr_stb = 0; sleep_stb = 0; clk_fail = 0;
        step(k - 1);
        chk({tag, " moved expiry later"}, rst_req, 1'b0);
        step(1);
        chk({tag, " full period after clear"}, rst_req, 1'b1);
    endtask

    task automatic t_priority();
        int k = 512;
        idle();
        ps_sel = 4'd2; cfg_en = 1;
        step(k - 1);
        clr_stb = 1;
        step(1);
        chk("R11 clear beats expiry", rst_req, 1'b0);
        clr_stb = 0;
        step(k - 1);
        chk("R11 quiet after clear", rst_req, 1'b0);
        step(1);
        chk("R11 restart from zero", rst_req, 1'b1);
    endtask

    task automatic t_disable();
        int k = 512;
        bit seen = 0;
        idle();
        ps_sel = 4'd2; cfg_en = 1;
        step(200);
        cfg_en = 0;
        #1 chk("R1 osc_en off when disabled", osc_en, 1'b0);
        for (int i = 0; i < k + 20; i++) begin
            step(1);
            if (rst_req | wake_req) seen = 1;
        end
        chk("R8 no request while disabled", seen, 1'b0);
        cfg_en = 1;
        step(k - 1);
        chk("R8 quiet after re-enable", rst_req, 1'b0);
        step(1);
        chk("R8 full period after re-enable", rst_req, 1'b1);
    endtask

    task automatic t_sw_ignored();
        int k = 512;
        idle();
        ps_sel = 4'd2; cfg_en = 1; sw_en = 1;
        step(100);
        sw_en = 0;
        #1 chk("R10 osc_en kept by cfg", osc_en, 1'b1);
        step(k - 101);
        chk("R10 quiet before period", rst_req, 1'b0);
        step(1);
        chk("R10 sw_en drop has no effect", rst_req, 1'b1);
    endtask

    task automatic t_dev_reset();
        int k = 512;
        idle();
        ps_sel = 4'd2; cfg_en = 1;
        step(k - 5);
        rst_n = 0;
        step(2);
        chk("R9 no request in reset", rst_req, 1'b0);
        rst_n = 1;
        step(k - 1);
        chk("R9 quiet after reset release", rst_req, 1'b0);
        step(1);
        chk("R9 full period after reset", rst_req, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_period(0, 0, 0);
        t_period(1, 0, 0);
        t_period(3, 0, 0);
        t_period(8, 0, 0);
        t_period(2, 1, 0);
        t_period(2, 0, 1);
        t_clear(0);
        t_clear(1);
        t_clear(2);
        t_priority();
        t_disable();
        t_sw_ignored();
        t_dev_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule